// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive approximation converter. After a start request it empties its trial register for one cycle. It then runs a binary search over the code, one bit per clock from the most significant bit down to the least significant bit. The trial code drives an external DAC, and a single comparator bit reports whether the DAC level lies at or below the held input. When the last bit has been decided, the block raises its done flag and leaves the code in place until the next start.

A result register sits behind the search. It takes the trial code only while the done flag is high. The converter's main output therefore keeps the previous valid code for the whole time a new search runs. A start request that arrives while a search is running aborts it and goes back to the clear step. The clock sets the conversion rate, and the code width is a parameter.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, the trial code, the done flag and the result are all zero.
- R2: On the clock edge that samples start high, every trial bit clears to 0 and the done flag goes low, whatever state the block was in.
- R3: One edge after the clear, the trial code holds only its most significant bit at 1.
- R4: On each trial edge, a comparator bit of 1 (DAC level not above the input) keeps the bit under trial at 1, and a 0 clears it. The same edge sets the next lower bit to 1 as the new trial.
- R5: The done flag rises on the WIDTH+1-th edge after the edge that sampled start: one clear cycle plus WIDTH trial cycles.
- R6: With an ideal DAC whose output for code c is (c+1)/2^WIDTH of the reference, the final code is the largest code whose DAC output does not exceed the input, or 0 when no code qualifies.
- R7: The result register loads the trial code only while the done flag is high. It does not change while a search runs.
- R8: A start during a search restarts it from the clear step. The result keeps the previous value until the new search completes.
- R9: Once done, the block stays idle: the done flag stays high and the trial code stays fixed, whatever the comparator does, until the next start.
- R10: WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on the rising edge |
| cmp_hi_i | input | 1 | Comparator bit, 1 when the DAC level is not above the input |
| trial_o | output | WIDTH | Trial code driven to the DAC |
| eoc_o | output | 1 | Done flag, high while the code is valid |
| result_o | output | WIDTH | Latched conversion result |

## Verification
A full sweep of input levels from zero to full scale covers both ends of the range. A design that cleared a bit on the wrong comparator polarity, or that tested a bit in the wrong order, would give codes off by one or by a whole bit weight. Edge counts from start to done would expose a missing clear cycle or an extra trial. A start during a search checks that the search restarts and that the old result stays on the output: a latch that followed the trial code directly would show partial codes there. After done, the bench toggles the comparator and watches the trial code and the flag. An idle state that kept deciding bits would change the code.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CLR  = 2'd1,
      ST_TRY  = 2'd2,
      ST_DONE = 2'd3
   } sar_state_t;
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             load_msb_o,
   output logic             step_o,
   output logic [WIDTH-1:0] ptr_o,
   output logic             eoc_o
);
   localparam logic [WIDTH-1:0] MSB_HOT = {1'b1, {(WIDTH-1){1'b0}}};

   sar_state_t       state_q;
   logic [WIDTH-1:0] ptr_q;
   logic             eoc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         eoc_q   <= 1'b0;
      end else if (start_i) begin
         state_q <= ST_CLR;
         ptr_q   <= '0;
         eoc_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_CLR: begin
               state_q <= ST_TRY;
               ptr_q   <= MSB_HOT;
            end
            ST_TRY: begin
               ptr_q <= ptr_q >> 1;
               if (ptr_q[0]) begin
                  state_q <= ST_DONE;
                  eoc_q   <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign load_msb_o = (state_q == ST_CLR);
   assign step_o     = (state_q == ST_TRY);
   assign ptr_o      = ptr_q;
   assign eoc_o      = eoc_q;

   // R4: exactly one bit is under trial while searching
   a_r4_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> $onehot(ptr_q));
   // R5: done rises only straight out of the last trial cycle
   a_r5_done_after_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_q) |-> ($past(state_q) == ST_TRY && $past(ptr_q[0])));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_msb_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] ptr_i,
   input  logic             cmp_hi_i,
   output logic [WIDTH-1:0] trial_o
);
   logic [WIDTH-1:0] trial_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic next_trial;
      if (i == WIDTH - 1) begin : g_top
         assign next_trial = 1'b0;
      end else begin : g_low
         assign next_trial = ptr_i[i+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            trial_q[i] <= 1'b0;
         else if (clr_i)        trial_q[i] <= 1'b0;
         else if (load_msb_i)   trial_q[i] <= (i == WIDTH - 1);
         else if (step_i) begin
            if (ptr_i[i])       trial_q[i] <= cmp_hi_i;
            else if (next_trial) trial_q[i] <= 1'b1;
         end
      end
   end

   assign trial_o = trial_q;

   // R3: the first trial holds only the top bit
   a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (load_msb_i && !clr_i) |=> (trial_q == {1'b1, {(WIDTH-1){1'b0}}}));
   // R4: a high comparator keeps the bit under trial
   a_r4_keep_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && cmp_hi_i && !clr_i) |=> ((trial_q & $past(ptr_i)) != '0));
   // R4: a low comparator clears the bit under trial
   a_r4_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !cmp_hi_i && !clr_i) |=> ((trial_q & $past(ptr_i)) == '0));
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eoc_i,
   input  logic [WIDTH-1:0] code_i,
   output logic [WIDTH-1:0] result_o
);
   logic [WIDTH-1:0] result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     result_q <= '0;
      else if (eoc_i) result_q <= code_i;
   end

   assign result_o = result_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_hi_i,
   output logic [WIDTH-1:0] trial_o,
   output logic             eoc_o,
   output logic [WIDTH-1:0] result_o
);
   // R10: the search needs at least two bits
   if (WIDTH < 2) begin : g_width_check
      $error("sar_conv_ctrl: WIDTH must be at least 2");
   end

   logic             load_msb;
   logic             step;
   logic [WIDTH-1:0] ptr;

   sar_sequencer #(.WIDTH(WIDTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .load_msb_o (load_msb),
      .step_o     (step),
      .ptr_o      (ptr),
      .eoc_o      (eoc_o)
   );

   sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start_i),
      .load_msb_i (load_msb),
      .step_i     (step),
      .ptr_i      (ptr),
      .cmp_hi_i   (cmp_hi_i),
      .trial_o    (trial_o)
   );

   sar_out_latch #(.WIDTH(WIDTH)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .eoc_i    (eoc_o),
      .code_i   (trial_o),
      .result_o (result_o)
   );

   // R2: a start clears the code and drops done
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (trial_o == '0 && !eoc_o));
   // R7: the result never moves while done is low
   a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_o |=> $stable(result_o));
   // R9: idle after done until the next start
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_o && !start_i) |=> (eoc_o && $stable(trial_o)));
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
   localparam int WIDTH    = 8;
   localparam int FULL     = 1 << WIDTH;
   localparam int CLK_PER  = 10;
   localparam int N_VEC    = 10;
   localparam int WD_LIMIT = 100000;

   // {input level, expected code}
   localparam int VEC [N_VEC][2] = '{
      '{0, 0}, '{1, 0}, '{2, 1}, '{128, 127}, '{129, 128},
      '{200, 199}, '{255, 254}, '{256, 255}, '{64, 63}, '{17, 16}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             cmp_hi;
   logic [WIDTH-1:0] trial;
   logic             eoc;
   logic [WIDTH-1:0] result;
   int               vin = 0;
   int               total = 0;
   int               bad = 0;
   int               cycles = 0;
   bit               finished = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   // ideal DAC and comparator: level of code c is c+1 steps
   assign cmp_hi = (int'(trial) + 1 <= vin);

   sar_conv_ctrl #(.WIDTH(WIDTH)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .cmp_hi_i (cmp_hi),
      .trial_o  (trial),
      .eoc_o    (eoc),
      .result_o (result)
   );

   function automatic int expect_code(input int v);
      if (v <= 0) return 0;
      if (v > FULL) return FULL - 1;
      return v - 1;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drives start for one edge; returns at the negedge after that edge
   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   // full conversion from a start pulse; checks timing, hold and result
   task automatic convert(input int level, input int exp);
      int held;
      int n;
      bit moved;
      vin = level;
      held = int'(result);
      moved = 1'b0;
      pulse_start();
      n = 0;
      while (!eoc && n < 3 * WIDTH) begin
         @(negedge clk);
         n++;
         if (!eoc && int'(result) != held) moved = 1'b1;
      end
      check("R5 edges to done", n, WIDTH + 1);
      check("R7 result held during search", int'(moved), 0);
      @(negedge clk);
      check("R6 final code", int'(result), exp);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", WD_LIMIT, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int snap;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 trial at reset", int'(trial), 0);
      check("R1 done at reset", int'(eoc), 0);
      check("R1 result at reset", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2, R3, R4 step-by-step trace, input 200
      vin = 200;
      pulse_start();
      check("R2 trial cleared", int'(trial), 0);
      check("R2 done low", int'(eoc), 0);
      @(negedge clk);
      check("R3 MSB trial", int'(trial), 128);
      @(negedge clk);
      check("R4 MSB kept, next set", int'(trial), 192);
      repeat (WIDTH) @(negedge clk);
      check("R6 trace result", int'(result), 199);

      // R4 cleared path, input 100
      vin = 100;
      pulse_start();
      repeat (2) @(negedge clk);
      check("R4 MSB dropped, next set", int'(trial), 64);
      repeat (WIDTH) @(negedge clk);
      check("R6 second result", int'(result), 99);

      // table walk
      for (int k = 0; k < N_VEC; k++) convert(VEC[k][0], VEC[k][1]);

      // full sweep
      for (int v = 0; v <= FULL; v++) convert(v, expect_code(v));

      // R9 idle: comparator toggles, nothing moves
      convert(77, 76);
      snap = int'(trial);
      for (int k = 0; k < 6; k++) begin
         vin = (k % 2) ? 0 : FULL;
         @(negedge clk);
         check("R9 done stays high", int'(eoc), 1);
         check("R9 trial fixed", int'(trial), snap);
         check("R9 result fixed", int'(result), 76);
      end

      // R8 abort: restart mid-search, old result stays
      vin = 30;
      pulse_start();
      repeat (3) @(negedge clk);
      check("R8 result kept mid-search", int'(result), 76);
      convert(180, 179);
      check("R8 restarted result", int'(result), 179);

      // R2 start while done drops the flag
      vin = 5;
      pulse_start();
      check("R2 done drops on restart", int'(eoc), 0);
      check("R8 old result kept", int'(result), 179);
      repeat (WIDTH + 1) @(negedge clk);
      check("R5 done after restart", int'(eoc), 1);
      @(negedge clk);
      check("R6 small input", int'(result), 4);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) cycles <= cycles + 1;
endmodule